// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a byte-addressed memory that sits on a two-wire serial bus as a target device, in the manner of a small serial EEPROM. A controller opens a transfer with a start condition and then sends an address byte. That byte holds the fixed 4-bit pattern 1010, then three select bits, then a direction bit. The block compares the select bits against its strap pins. It acknowledges by pulling SDA low during the ninth clock and stays silent otherwise. Writes load a word address and then store one or more data bytes. Reads return bytes starting from an internal word address counter. That counter survives from one transaction to the next.

The counter advances in two different ways. After a write it moves forward inside the current page only. After a read it moves across the whole array and wraps from the top byte back to byte 0. A stop that closes a write starts an internal write-cycle timer. Until the timer expires, the block ignores its own address so that the controller can poll for completion. For larger arrays, the low select bits carry the upper memory-address bits. SCL and SDA are brought into the system clock through two-flop synchronisers. SDA is only ever pulled low; it is never driven high.

Top module: `serial_eeprom_target`

## Requirements
- R1: An address byte is accepted only if bits 7:4 equal 1010 and bits 3:1 equal `devSel`; bit 0 set means read and clear means write. On any other address byte SDA stays released in the acknowledge slot.
- R2: In a write, the byte after the address byte loads the word address counter. Each following data byte is stored at the counter, and every one of these bytes is acknowledged with a low level in the ninth clock.
- R3: After each stored byte, the counter moves forward within its page only: the byte after the last byte of a page lands on the first byte of that same page.
- R4: A read whose address byte arrives with no word address first returns the byte at the counter. The counter holds the last address read or written plus one, and it keeps that value across transactions.
- R5: A write of the address byte and the word address, followed by a repeated start and a read, returns the byte stored at that word address.
- R6: While the controller acknowledges each read byte with a low level, the block keeps sending successive bytes. The address wraps from the last byte of the array to byte 0.
- R7: A high level (NACK) from the controller after a read byte ends the read, and SDA is released.
- R8: A stop that follows at least one stored data byte makes the block busy for WRITE_CYCLES clocks. While it is busy, its own address byte is not acknowledged; once the time has passed, it is acknowledged again.
- R9: A start condition at any bit position abandons the byte in progress, and bit counting restarts for a new address byte. The partial byte is not stored.
- R10: SDA is only pulled low, never driven high. The pull-down changes only while SCL is low; a start or stop is the only exception.
- R11: After reset, SDA is released, the block is not busy, the counter is 0 and every memory byte reads 0.
- R12: A stop or repeated start with no data byte stored does not start the write timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| scl | input | 1 | Serial clock from the bus |
| sdaIn | input | 1 | Level seen on the serial data line |
| devSel | input | 3 | Strap pins matched against address bits 3:1 |
| sdaPullLow | output | 1 | Pull-down enable for SDA (open-drain) |

## Verification
The bench builds the block with 256 bytes, 8-byte pages and a write cycle of 400 clocks. That cycle is longer than one address byte on the bus, so the first poll after a write is always refused. It is short enough that polling succeeds within a few tries, so both sides of the busy window can be reached. Keeping 256 bytes means the top byte and byte 0 are ordinary table entries, so the read wrap is checked with them. A page write that starts two bytes before a page boundary shows the wrap inside the page.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } busState_t;

  typedef struct packed {
    logic loadAddr;
    logic writeByte;
    logic loadTx;
    logic shiftTx;
    logic startBusy;
  } strobes_t;

endpackage

// File: rtl/seeprom_bus_ctrl.sv
module seeprom_bus_ctrl
  import seeprom_pkg::*;
#(
  parameter int MEM_BYTES = 256
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         scl,
  input  logic                         sdaIn,
  input  logic [2:0]                   devSel,
  input  logic                         busy,
  input  logic                         txBit,
  output strobes_t                     strobe,
  output logic [$clog2(MEM_BYTES)-1:0] wordAddr,
  output logic [7:0]                   dataByte,
  output logic                         sdaPullLow
);

  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int HI_BITS = (ADDR_W > 8) ? ADDR_W - 8 : 0;
  localparam logic [2:0] SEL_MASK = 3'(3'b111 << HI_BITS);

  logic sclM, sclS, sclP, sdaM, sdaS, sdaP;
  logic startDet, stopDet, sclRise, sclFall;

  busState_t state, stateN;
  logic [3:0] bitCnt, bitCntN;
  logic [7:0] rxShift, rxN;
  logic ackDrive, ackDriveN;
  logic isRead, isReadN;
  logic hostAck, hostAckN;
  logic wrote, wroteN;
  logic devAccept, addrMatch;

  // two-flop synchronisers plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      {sclM, sclS, sclP} <= 3'b111;
      {sdaM, sdaS, sdaP} <= 3'b111;
    end else begin
      sclM <= scl;
      sclS <= sclM;
      sclP <= sclS;
      sdaM <= sdaIn;
      sdaS <= sdaM;
      sdaP <= sdaS;
    end
  end

  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;
  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;

  assign addrMatch = (rxShift[7:4] == 4'b1010) &&
                     (((rxShift[3:1] ^ devSel) & SEL_MASK) == 3'b000);

  always_comb begin
    stateN    = state;
    bitCntN   = bitCnt;
    rxN       = rxShift;
    ackDriveN = ackDrive;
    isReadN   = isRead;
    hostAckN  = hostAck;
    wroteN    = wrote;
    devAccept = 1'b0;
    strobe    = '0;
    if (startDet) begin
      stateN    = ST_DEV;
      bitCntN   = 4'd0;
      ackDriveN = 1'b0;
    end else if (stopDet) begin
      stateN    = ST_IDLE;
      bitCntN   = 4'd0;
      ackDriveN = 1'b0;
      if (wrote) begin
        strobe.startBusy = 1'b1;
        wroteN           = 1'b0;
      end
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (sclRise && bitCnt < 4'd8) begin
            rxN     = {rxShift[6:0], sdaS};
            bitCntN = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            bitCntN = 4'd0;
            if (state == ST_DEV) begin
              if (addrMatch && !busy) begin
                devAccept = 1'b1;
                ackDriveN = 1'b1;
                isReadN   = rxShift[0];
                stateN    = ST_DEV_ACK;
              end else begin
                stateN = ST_IDLE;
              end
            end else if (state == ST_WADDR) begin
              ackDriveN       = 1'b1;
              strobe.loadAddr = 1'b1;
              stateN          = ST_WADDR_ACK;
            end else begin
              ackDriveN        = 1'b1;
              strobe.writeByte = 1'b1;
              wroteN           = 1'b1;
              stateN           = ST_WDATA_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (sclFall) begin
            ackDriveN = 1'b0;
            if (isRead) begin
              strobe.loadTx = 1'b1;
              stateN        = ST_RDATA;
            end else begin
              stateN = ST_WADDR;
            end
          end
        end
        ST_WADDR_ACK, ST_WDATA_ACK: begin
          if (sclFall) begin
            ackDriveN = 1'b0;
            stateN    = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclRise) begin
            bitCntN = bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              bitCntN = 4'd0;
              stateN  = ST_RACK;
            end else begin
              strobe.shiftTx = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            hostAckN = ~sdaS;
          end else if (sclFall) begin
            if (hostAck) begin
              strobe.loadTx = 1'b1;
              stateN        = ST_RDATA;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        default: stateN = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= 4'd0;
      rxShift  <= 8'd0;
      ackDrive <= 1'b0;
      isRead   <= 1'b0;
      hostAck  <= 1'b0;
      wrote    <= 1'b0;
    end else begin
      state    <= stateN;
      bitCnt   <= bitCntN;
      rxShift  <= rxN;
      ackDrive <= ackDriveN;
      isRead   <= isReadN;
      hostAck  <= hostAckN;
      wrote    <= wroteN;
    end
  end

  // upper memory-address bits borrowed from the select field on large arrays
  generate
    if (HI_BITS > 0) begin : g_hiAddr
      logic [HI_BITS-1:0] hiReg;
      always_ff @(posedge clk) begin
        if (!rstN) hiReg <= '0;
        else if (devAccept) hiReg <= rxShift[HI_BITS:1];
      end
      assign wordAddr = {hiReg, rxShift};
    end else begin : g_byteAddr
      assign wordAddr = rxShift[ADDR_W-1:0];
    end
  endgenerate

  assign dataByte   = rxShift;
  assign sdaPullLow = ackDrive | ((state == ST_RDATA) & ~txBit);

  // R1
  addr_mismatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEV && !startDet && !stopDet && sclFall && bitCnt == 4'd8 &&
     rxShift[7:4] != 4'b1010) |=> !sdaPullLow);

  // R8
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEV_ACK) |-> !busy);

  // R9
  abort_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_DEV && bitCnt == 4'd0));

  // R7
  nack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RACK && !startDet && !stopDet && sclFall && !hostAck)
      |=> (state == ST_IDLE && !sdaPullLow));

  // R10
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && sclP && !startDet && !stopDet) |-> $stable(sdaPullLow));

endmodule

// File: rtl/seeprom_store.sv
module seeprom_store
  import seeprom_pkg::*;
#(
  parameter int MEM_BYTES    = 256,
  parameter int PAGE_BYTES   = 8,
  parameter int WRITE_CYCLES = 5000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobes_t                     strobe,
  input  logic [$clog2(MEM_BYTES)-1:0] wordAddr,
  input  logic [7:0]                   dataByte,
  output logic                         txBit,
  output logic                         busy
);

  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int BUSY_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(WRITE_CYCLES);

  logic [7:0]        mem [MEM_BYTES];
  logic [ADDR_W-1:0] ptr, pageNext;
  logic [7:0]        txReg;
  logic [BUSY_W-1:0] busyCnt;

  // next write address stays inside the current page
  generate
    if (PAGE_W == 0) begin : g_noPage
      assign pageNext = ptr;
    end else if (PAGE_W >= ADDR_W) begin : g_onePage
      assign pageNext = ptr + 1'b1;
    end else begin : g_page
      logic [PAGE_W-1:0] lowNext;
      assign lowNext  = ptr[PAGE_W-1:0] + 1'b1;
      assign pageNext = {ptr[ADDR_W-1:PAGE_W], lowNext};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr     <= '0;
      txReg   <= 8'd0;
      busyCnt <= '0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'd0;
    end else begin
      if (strobe.loadAddr) ptr <= wordAddr;
      if (strobe.writeByte) begin
        mem[ptr] <= dataByte;
        ptr      <= pageNext;
      end
      if (strobe.loadTx) begin
        txReg <= mem[ptr];
        ptr   <= ptr + 1'b1;
      end else if (strobe.shiftTx) begin
        txReg <= {txReg[6:0], 1'b0};
      end
      if (strobe.startBusy) busyCnt <= BUSY_LOAD;
      else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
    end
  end

  assign txBit = txReg[7];
  assign busy  = (busyCnt != '0);

  // R8
  busy_countdown_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyCnt != '0) |=> (busyCnt == $past(busyCnt) - 1'b1));

  // R3
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeByte |=> (((ptr ^ $past(ptr)) >> PAGE_W) == '0));

  // R6
  read_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadTx && ptr == ADDR_W'(MEM_BYTES - 1)) |=> (ptr == '0));

  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadAddr |=> (ptr == $past(wordAddr)));

endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target
  import seeprom_pkg::*;
#(
  parameter int MEM_BYTES    = 256,
  parameter int PAGE_BYTES   = 8,
  parameter int WRITE_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sdaIn,
  input  logic [2:0] devSel,
  output logic       sdaPullLow
);

  localparam int ADDR_W = $clog2(MEM_BYTES);

  strobes_t          strobe;
  logic [ADDR_W-1:0] wordAddr;
  logic [7:0]        dataByte;
  logic              txBit;
  logic              busy;

  seeprom_bus_ctrl #(.MEM_BYTES(MEM_BYTES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .scl       (scl),
    .sdaIn     (sdaIn),
    .devSel    (devSel),
    .busy      (busy),
    .txBit     (txBit),
    .strobe    (strobe),
    .wordAddr  (wordAddr),
    .dataByte  (dataByte),
    .sdaPullLow(sdaPullLow)
  );

  seeprom_store #(
    .MEM_BYTES   (MEM_BYTES),
    .PAGE_BYTES  (PAGE_BYTES),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wordAddr (wordAddr),
    .dataByte (dataByte),
    .txBit    (txBit),
    .busy     (busy)
  );

endmodule

// File: tb/serial_eeprom_target_bench.sv
module serial_eeprom_target_bench;

  localparam int Q = 5;
  localparam logic [7:0] DEVW = 8'hAA;
  localparam logic [7:0] DEVR = 8'hAB;
  localparam logic [7:0] BADW = 8'hA0;

  // {isRead, addr, data}
  localparam logic [16:0] VEC [9] = '{
    {1'b0, 8'h10, 8'hA5},
    {1'b0, 8'h11, 8'h3C},
    {1'b0, 8'hFF, 8'h7E},
    {1'b0, 8'h00, 8'h81},
    {1'b1, 8'h10, 8'hA5},
    {1'b1, 8'hFF, 8'h7E},
    {1'b1, 8'h11, 8'h3C},
    {1'b1, 8'h00, 8'h81},
    {1'b1, 8'h55, 8'h00}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic sdaPullLow;
  logic sdaLine;
  logic done = 1'b0;
  int nChecks = 0;
  int nFail = 0;
  int r10Bad = 0;
  int highCnt = 0;
  logic prevPull = 1'b0;
  logic [7:0] got [8];

  always #4 clk = ~clk;

  assign sdaLine = sdaDrv & ~sdaPullLow;

  serial_eeprom_target #(
    .MEM_BYTES(256), .PAGE_BYTES(8), .WRITE_CYCLES(400)
  ) u_serial_eeprom_target (
    .clk(clk), .rstN(rstN), .scl(sclDrv), .sdaIn(sdaLine),
    .devSel(3'b101), .sdaPullLow(sdaPullLow)
  );

  // R10 monitor: no change of the pull-down deep inside an SCL high phase
  always @(negedge clk) begin
    if (rstN) begin
      highCnt = sclDrv ? highCnt + 1 : 0;
      if (highCnt >= 4 && sdaPullLow != prevPull) r10Bad++;
      prevPull = sdaPullLow;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; wq();
    sclDrv = 1'b1; wq();
    sdaDrv = 1'b0; wq();
    sclDrv = 1'b0; wq();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; wq();
    sclDrv = 1'b1; wq();
    sdaDrv = 1'b1; wq();
  endtask

  task automatic sendBit(input logic b);
    sdaDrv = b; wq();
    sclDrv = 1'b1; wq(); wq();
    sclDrv = 1'b0; wq();
  endtask

  task automatic recvBit(output logic b);
    sdaDrv = 1'b1; wq();
    sclDrv = 1'b1; wq();
    b = sdaLine; wq();
    sclDrv = 1'b0; wq();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(b);
    ack = ~b;
  endtask

  task automatic recvByte(output logic [7:0] v, input logic giveAck);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      v[i] = b;
    end
    sendBit(~giveAck);
  endtask

  task automatic pollReady();
    logic ack;
    logic firstAck;
    int polls = 0;
    firstAck = 1'b1;
    ack = 1'b0;
    while (!ack && polls < 20) begin
      busStart();
      sendByte(DEVW, ack);
      if (polls == 0) firstAck = ack;
      polls++;
    end
    busStop();
    chk("R8 first poll refused", int'(firstAck), 0);
    chk("R8 accepted after write cycle", int'(ack), 1);
  endtask

  task automatic seqRead(input logic [7:0] addr, input int n);
    logic ack;
    busStart();
    sendByte(DEVW, ack);
    sendByte(addr, ack);
    busStart();
    sendByte(DEVR, ack);
    chk("R5 read address acknowledged", int'(ack), 1);
    for (int i = 0; i < n; i++) recvByte(got[i], i != n - 1);
    busStop();
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    wq();

    // R11 reset state
    chk("R11 SDA released after reset", int'(sdaPullLow), 0);
    busStart();
    sendByte(DEVR, ack);
    chk("R11 not busy after reset", int'(ack), 1);
    recvByte(d, 1'b0);
    busStop();
    chk("R11 memory clear after reset", int'(d), 0);

    // vector table: byte writes with busy polling, random reads
    for (int v = 0; v < 9; v++) begin
      if (!VEC[v][16]) begin
        busStart();
        sendByte(DEVW, ack);
        chk("R2 address ack", int'(ack), 1);
        sendByte(VEC[v][15:8], ack);
        chk("R2 word address ack", int'(ack), 1);
        sendByte(VEC[v][7:0], ack);
        chk("R2 data ack", int'(ack), 1);
        busStop();
        pollReady();
      end else begin
        seqRead(VEC[v][15:8], 1);
        chk("R5 random read data", int'(got[0]), int'(VEC[v][7:0]));
      end
    end

    // R4 current-address read follows the last access
    seqRead(8'h10, 1);
    chk("R5 random read at 10", int'(got[0]), 8'hA5);
    busStart();
    sendByte(DEVR, ack);
    recvByte(d, 1'b0);
    busStop();
    chk("R4 current address read", int'(d), 8'h3C);

    // R1 wrong select bits
    busStart();
    sendByte(BADW, ack);
    chk("R1 mismatched select refused", int'(ack), 0);
    busStop();

    // R3 page write across the page end
    busStart();
    sendByte(DEVW, ack);
    sendByte(8'h2E, ack);
    for (int i = 1; i <= 4; i++) begin
      sendByte(8'(i), ack);
      chk("R2 page data ack", int'(ack), 1);
    end
    busStop();
    pollReady();
    seqRead(8'h28, 8);
    begin
      logic [7:0] expPage [8];
      expPage = '{8'h03, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h02};
      for (int i = 0; i < 8; i++)
        chk("R3 page wrap content", int'(got[i]), int'(expPage[i]));
    end

    // R6 array wrap on sequential read, R7 NACK release
    busStart();
    sendByte(DEVW, ack);
    sendByte(8'hFE, ack);
    busStart();
    sendByte(DEVR, ack);
    for (int i = 0; i < 3; i++) recvByte(got[i], i != 2);
    chk("R7 SDA released after NACK", int'(sdaPullLow), 0);
    busStop();
    chk("R6 byte FE", int'(got[0]), 8'h00);
    chk("R6 byte FF", int'(got[1]), 8'h7E);
    chk("R6 wrap to byte 00", int'(got[2]), 8'h81);

    // R9 start inside an address byte
    busStart();
    for (int i = 0; i < 3; i++) sendBit(1'b1);
    busStart();
    sendByte(DEVW, ack);
    chk("R9 address after aborted byte", int'(ack), 1);
    sendByte(8'h40, ack);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    // R9 repeated start inside a data byte; R12 no timer started
    busStart();
    sendByte(DEVR, ack);
    chk("R12 no busy after aborted data", int'(ack), 1);
    recvByte(d, 1'b0);
    busStop();
    chk("R9 partial byte not stored", int'(d), 8'h00);

    chk("R10 pull-down steady while SCL high", r10Bad, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule